// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) and returns the full `2*WIDTH`-bit product. It takes one clock cycle per multiplier bit. The datapath uses three resources:

- a multiplicand register that holds its value for the whole operation;
- one `WIDTH`-bit adder that keeps its carry-out;
- a double-width product register.

The multiplier operand is loaded into the low half of the product register. There is no separate multiplier register. Each step looks at bit 0 of the product register:

- If bit 0 is set, the adder adds the multiplicand to the upper half.
- The carry-out, the upper half and the lower half are then shifted right together by one place.
- The lowest multiplier bit drops out, and the next one moves into bit 0.

The operand input is a one-sided handshake. `start` acts as the valid signal and `!busy` acts as ready:

- An operand pair is taken on a clock edge where `start` is high and `busy` is low.
- While `busy` is high, `start` is ignored and the operands are not captured.
- The result side has no back-pressure. `done` pulses for one cycle when the product is final.
- `product` then holds that value until the next operand pair is accepted.

Top module: `seq_mult`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: When `done` is high, `product` equals the full unsigned product of the accepted `op_a` and `op_b`, with no bits lost.
- R3: `done` rises on exactly the `WIDTH`-th rising clock edge after the edge that accepted the operands (32 edges by default), and `busy` falls on that same edge.
- R4: `done` is high for exactly one clock cycle per multiply.
- R5: A `start` pulse while `busy` is high has no effect. The result and the latency of the multiply in progress are unchanged.
- R6: While the block is idle and `start` is low, `product` does not change. The last result stays readable.
- R7: `busy` is high in the cycle right after an accepted `start`, and it stays high until the edge where `done` rises.
- R8: The adder carry-out is kept on every step. The all-ones case 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand valid; accepted only when `busy` is low |
| op_a | input | WIDTH | Multiplicand, captured on acceptance |
| op_b | input | WIDTH | Multiplier, captured on acceptance |
| busy | output | 1 | High while a multiply is in progress; its inverse is operand ready |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | 2*WIDTH | Unsigned product, held until the next accepted start |

## Verification
The bound checker tests several properties on every cycle:

- the busy and done sequencing and the one-cycle width of `done`;
- the exact step count from acceptance to `done`, using its own counter;
- that the product is stable while the block is idle;
- that the result at `done` equals the product of the operands it captured.

Some properties can only be shown by the bench scenarios:

- the result is correct across different operand patterns and the carry-heavy all-ones corner;
- `start` pulses during a run leave the result untouched;
- the operands seen at reset and at back-to-back starts are handled correctly.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic [0:0] {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } mult_state_t;
endpackage

// File: rtl/seq_mult_adder.sv
// Single-width adder; the carry-out feeds the top of the shift.
module seq_mult_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addend_a,
  input  logic [WIDTH-1:0] addend_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  logic [WIDTH:0] full_sum;

  always_comb begin
    full_sum  = {1'b0, addend_a} + {1'b0, addend_b};
    sum       = full_sum[WIDTH-1:0];
    carry_out = full_sum[WIDTH];
  end
endmodule

// File: rtl/seq_mult_ctrl.sv
// Step sequencer: accepts a request when idle, then counts WIDTH steps.
module seq_mult_ctrl
  import seq_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  mult_state_t     state_q;
  logic [CW-1:0]   step_cnt_q;

  assign load = (state_q == MS_IDLE) && start;
  assign step = (state_q == MS_RUN);
  assign busy = (state_q == MS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MS_IDLE;
      step_cnt_q <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        MS_IDLE: begin
          if (start) begin
            state_q    <= MS_RUN;
            step_cnt_q <= '0;
          end
        end
        MS_RUN: begin
          if (step_cnt_q == LAST_STEP) begin
            state_q <= MS_IDLE;
            done    <= 1'b1;
          end
          step_cnt_q <= step_cnt_q + 1'b1;
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_mult_datapath.sv
// Fixed multiplicand, double-width product register shifting right.
module seq_mult_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH-1:0] add_in;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic [PW:0]      pre_shift;

  // Bit 0 of the product register is the current multiplier bit.
  assign add_in = prod_q[0] ? mcand_q : '0;

  seq_mult_adder #(.WIDTH(WIDTH)) u_adder (
    .addend_a (prod_q[PW-1:WIDTH]),
    .addend_b (add_in),
    .sum      (add_sum),
    .carry_out(add_cout)
  );

  assign pre_shift = {add_cout, add_sum, prod_q[WIDTH-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= op_a;
      prod_q  <= {{WIDTH{1'b0}}, op_b};
    end else if (step) begin
      prod_q  <= pre_shift[PW:1];
    end
  end

  assign product = prod_q;
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load;
  logic step;

  seq_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .step (step),
    .busy (busy),
    .done (done)
  );

  seq_mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .op_a   (op_a),
    .op_b   (op_b),
    .product(product)
  );
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0]      lat_q;
  logic [2*WIDTH-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      exp_q <= '0;
    end else if (start && !busy) begin
      lat_q <= '0;
      exp_q <= {{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b};
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == CW'(WIDTH))); // R3
  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R6
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
endmodule

bind seq_mult seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op_a   (op_a),
  .op_b   (op_b),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/seq_mult_test.sv
module seq_mult_test;
  localparam int  W      = 32;
  localparam time CLK_PD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          busy;
  logic          done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;

  seq_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  always #(CLK_PD/2) clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one multiply; optionally pulses start with other operands mid-run (R5).
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input string tag);
    int cycles;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = b + 1;
    check(busy === 1'b1, "R7 busy after start", {63'd0, busy}, 64'd1);
    cycles = 0;
    while (done !== 1'b1 && cycles < 100) begin
      if (poke && cycles == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    check(cycles == W, "R3 latency", 64'(cycles), 64'(W));
    check(busy === 1'b0, "R3 busy low at done", {63'd0, busy}, 64'd0);
    check(product === exp, {tag, (poke ? " R5 ignored start" : "")}, product, exp);
    @(negedge clk);
    check(done === 1'b0, "R4 done one cycle", {63'd0, done}, 64'd0);
    repeat (2) @(negedge clk);
    check(product === exp, "R6 idle hold", product, exp);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy reset", {63'd0, busy}, 64'd0);
    check(done === 1'b0, "R1 done reset", {63'd0, done}, 64'd0);
    check(product === '0, "R1 product reset", product, 64'd0);
    rst_n = 1'b1;
    run_mul(32'd0, 32'd0, 1'b0, "R2 zero");
    run_mul(32'd1, 32'hDEADBEEF, 1'b0, "R2 one");
    run_mul(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R8 all ones");
    run_mul(32'h80000000, 32'h80000000, 1'b0, "R8 top bits");
    run_mul(32'h12345678, 32'h9ABCDEF0, 1'b1, "R2 mid");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 8 == 0) rb = 32'hFFFFFFFF;
      run_mul(ra, rb, (i % 5 == 0), "R2 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule